// File: doc/BRIEF.md
# SRAM Controller with Posted Write Buffer

This block sits between a simple processor-side request bus and a single-port synchronous SRAM array, which it models inside itself as a register array. The bus is byte addressed. Each request carries a read or write flag, an access size of byte, halfword or word, an address and write data. The block aligns every access to its natural boundary by ignoring the low address bits that do not fit the access size.

Writes never wait. Each write lands in a one-entry posted buffer, and the array only receives that entry when the next write request arrives. Reads see the newest data. When a read hits the buffered word, the buffered byte lanes are laid over the array data.

The buffer is never drained on idle cycles or on reads. A reset therefore throws away whatever the buffer holds. Software that needs a write to survive a reset either repeats it, or follows it with a dummy write to any address.

Top module: `sram_postwr_ctrl`

## Requirements
- R1: A byte access (size code 0) addresses the byte lane given by address bits [1:0], where lane 0 is data bits [7:0]. A byte read returns that byte in bits [7:0], with bits [31:8] zero.
- R2: A word access (size code 2) ignores address bits [1:0] and uses the whole aligned 32-bit word.
- R3: A halfword access (size code 1) ignores address bit 0. Address bit 1 set selects bits [31:16], and clear selects bits [15:0]. A halfword read returns the half in bits [15:0], with bits [31:16] zero.
- R4: Every write is accepted in the cycle it is presented. Writes on consecutive cycles all take effect and lose nothing.
- R5: A buffered write is moved into the array only in a cycle that carries a new write request. Reads and idle cycles never move it.
- R6: Reset empties the buffer without writing it to the array, and returns no read data while it is held.
- R7: Two successive writes of the same data to the same location leave that data in the array across a reset. One write followed by a write to any other address has the same effect.
- R8: A read of a word that the buffer holds returns the buffered byte lanes merged over the array contents of the other lanes.
- R9: The read result appears with rd_valid exactly one cycle after the read request. rd_valid is low in every other cycle.
- R10: Reset does not clear the array contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, right-justified for byte and halfword |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data, right-justified and zero-extended |

## Verification
The hardest state to reach is one where the array and the buffer disagree about a location, because a read from the ports always shows the merged, newest value. The only way to observe what the array itself holds is to write data, pass through reads and idle cycles, and then reset. The reset discards the buffer, so a later read reveals the array alone. The stimulus first fixes a known value by writing it twice, then posts a different value to the same location before the reset, and also checks that a dummy write to another address makes an earlier write survive.

// File: rtl/sram_pw_pkg.sv
package sram_pw_pkg;
   localparam int DATA_W = 32;
   localparam int LANES  = DATA_W / 8;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;
endpackage

// File: rtl/sram_pw_lanes.sv
// Write lane encoder: builds byte enables and replicated write data.
module sram_pw_lanes
   import sram_pw_pkg::*;
(
   input  logic [1:0]        size,
   input  logic [1:0]        addr_lo,
   input  logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] wrep
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_comb begin
         case (acc_size_e'(size))
            SZ_WORD: begin
               be[l]          = 1'b1;
               wrep[l*8 +: 8] = wdata[l*8 +: 8];
            end
            SZ_HALF: begin
               be[l]          = ((l / 2) == int'(addr_lo[1]));
               wrep[l*8 +: 8] = wdata[(l % 2)*8 +: 8];
            end
            default: begin
               be[l]          = (l == int'(addr_lo));
               wrep[l*8 +: 8] = wdata[7:0];
            end
         endcase
      end
   end
endmodule

// File: rtl/sram_pw_buf.sv
// One-entry posted write buffer; drains only when a new write arrives.
module sram_pw_buf
   import sram_pw_pkg::*;
#(
   parameter int WORD_AW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_fire,
   input  logic [WORD_AW-1:0] new_idx,
   input  logic [LANES-1:0]   new_be,
   input  logic [DATA_W-1:0]  new_data,
   output logic               buf_valid,
   output logic [WORD_AW-1:0] buf_idx,
   output logic [LANES-1:0]   buf_be,
   output logic [DATA_W-1:0]  buf_data,
   output logic               commit_we
);
   assign commit_we = wr_fire & buf_valid;

   always_ff @(posedge clk) begin
      if (!rst_n)
         buf_valid <= 1'b0;
      else if (wr_fire)
         buf_valid <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_fire) begin
         buf_idx  <= new_idx;
         buf_be   <= new_be;
         buf_data <= new_data;
      end
   end
endmodule

// File: rtl/sram_pw_array.sv
// Single-port synchronous array with byte-lane write enables.
module sram_pw_array
   import sram_pw_pkg::*;
#(
   parameter int WORD_AW = 8,
   localparam int DEPTH  = 1 << WORD_AW
) (
   input  logic               clk,
   input  logic               we,
   input  logic [WORD_AW-1:0] widx,
   input  logic [LANES-1:0]   wbe,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               re,
   input  logic [WORD_AW-1:0] ridx,
   output logic [DATA_W-1:0]  rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int l = 0; l < LANES; l++)
            if (wbe[l]) mem[widx][l*8 +: 8] <= wdata[l*8 +: 8];
      end
      if (re)
         rdata <= mem[ridx];
   end
endmodule

// File: rtl/sram_pw_rdpath.sv
// Read return stage: merges forwarded lanes and right-justifies the result.
module sram_pw_rdpath
   import sram_pw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire,
   input  logic [1:0]        size,
   input  logic [1:0]        addr_lo,
   input  logic              hit,
   input  logic [LANES-1:0]  fwd_be,
   input  logic [DATA_W-1:0] fwd_data,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   logic [1:0]        size_q, lo_q;
   logic [LANES-1:0]  be_q;
   logic [DATA_W-1:0] fdata_q, merged;

   always_ff @(posedge clk) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_fire;
   end

   always_ff @(posedge clk) begin
      if (rd_fire) begin
         size_q  <= size;
         lo_q    <= addr_lo;
         be_q    <= hit ? fwd_be : '0;
         fdata_q <= fwd_data;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_merge
      assign merged[l*8 +: 8] = be_q[l] ? fdata_q[l*8 +: 8] : arr_rdata[l*8 +: 8];
   end

   always_comb begin
      case (acc_size_e'(size_q))
         SZ_WORD: rd_data = merged;
         SZ_HALF: rd_data = {16'h0, lo_q[1] ? merged[31:16] : merged[15:0]};
         default: rd_data = {24'h0, merged[lo_q*8 +: 8]};
      endcase
   end
endmodule

// File: rtl/sram_postwr_ctrl.sv
module sram_postwr_ctrl
   import sram_pw_pkg::*;
#(
   parameter int ADDR_W = 10,
   localparam int WORD_AW = ADDR_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rd_valid,
   output logic [31:0]       rd_data
);
   if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_aw
      $error("sram_postwr_ctrl: ADDR_W must lie in 3..16");
   end
   if (DATA_W != 32) begin : g_bad_dw
      $error("sram_postwr_ctrl: data path must be 32 bits");
   end

   logic               wr_fire, rd_fire, hit, commit_we, buf_valid;
   logic [WORD_AW-1:0] req_idx, buf_idx;
   logic [LANES-1:0]   wr_be, buf_be;
   logic [DATA_W-1:0]  wr_rep, buf_data, arr_rdata;

   assign wr_fire = req_valid &  req_write;
   assign rd_fire = req_valid & ~req_write;
   assign req_idx = req_addr[ADDR_W-1:2];

   sram_pw_lanes u_lanes (
      .size(req_size), .addr_lo(req_addr[1:0]), .wdata(req_wdata),
      .be(wr_be), .wrep(wr_rep)
   );

   sram_pw_buf #(.WORD_AW(WORD_AW)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire),
      .new_idx(req_idx), .new_be(wr_be), .new_data(wr_rep),
      .buf_valid(buf_valid), .buf_idx(buf_idx), .buf_be(buf_be),
      .buf_data(buf_data), .commit_we(commit_we)
   );

   sram_pw_array #(.WORD_AW(WORD_AW)) u_arr (
      .clk(clk), .we(commit_we), .widx(buf_idx), .wbe(buf_be), .wdata(buf_data),
      .re(rd_fire), .ridx(req_idx), .rdata(arr_rdata)
   );

   assign hit = buf_valid && (buf_idx == req_idx);

   sram_pw_rdpath u_rd (
      .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .size(req_size),
      .addr_lo(req_addr[1:0]), .hit(hit), .fwd_be(buf_be), .fwd_data(buf_data),
      .arr_rdata(arr_rdata), .rd_valid(rd_valid), .rd_data(rd_data)
   );
endmodule

// File: rtl/sram_postwr_chk.sv
module sram_postwr_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic [1:0]  req_size,
   input logic        rd_valid,
   input logic [31:0] rd_data,
   input logic        commit_we,
   input logic        buf_valid,
   input logic [3:0]  wr_be
);
   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid);                          // R9
   AST_RD_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rd_valid);                        // R9
   AST_COMMIT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_we |-> (req_valid && req_write));                          // R5
   AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_valid && !(req_valid && req_write)) |=> buf_valid);          // R5
   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> buf_valid);                          // R4
   AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == 2'd0) |=> (rd_data[31:8] == 24'h0)); // R1
   AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == 2'd1) |=> (rd_data[31:16] == 16'h0)); // R3
   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size == 2'd0) |-> ($countones(wr_be) == 1)); // R1
   AST_RST_EMPTY: assert property (@(posedge clk)
      !rst_n |=> (!buf_valid && !rd_valid));                            // R6
endmodule

bind sram_postwr_ctrl sram_postwr_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_size(req_size), .rd_valid(rd_valid), .rd_data(rd_data),
   .commit_we(commit_we), .buf_valid(buf_valid), .wr_be(wr_be)
);

// File: tb/sram_postwr_ctrl_test.sv
`timescale 1ns/1ps
module sram_postwr_ctrl_test;
   localparam int AW = 10;
   localparam int NV = 28;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]    req_size = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic          rd_valid;
   logic [31:0]   rd_data;
   int            n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   sram_postwr_ctrl #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   // {write, size, addr, wdata, expected, req number}
   localparam logic [80:0] VEC [NV] = '{
      {1'b1, 2'd2, 10'h010, 32'h11223344, 32'h0,        4'd2},  // R2
      {1'b1, 2'd2, 10'h014, 32'hAABBCCDD, 32'h0,        4'd4},  // R4
      {1'b0, 2'd2, 10'h010, 32'h0,        32'h11223344, 4'd2},  // R2
      {1'b0, 2'd2, 10'h013, 32'h0,        32'h11223344, 4'd2},  // R2
      {1'b0, 2'd2, 10'h016, 32'h0,        32'hAABBCCDD, 4'd8},  // R8
      {1'b0, 2'd0, 10'h011, 32'h0,        32'h00000033, 4'd1},  // R1
      {1'b0, 2'd0, 10'h017, 32'h0,        32'h000000AA, 4'd1},  // R1
      {1'b0, 2'd1, 10'h012, 32'h0,        32'h00001122, 4'd3},  // R3
      {1'b0, 2'd1, 10'h013, 32'h0,        32'h00001122, 4'd3},  // R3
      {1'b0, 2'd1, 10'h015, 32'h0,        32'h0000CCDD, 4'd3},  // R3
      {1'b1, 2'd0, 10'h011, 32'h000000EE, 32'h0,        4'd1},  // R1
      {1'b0, 2'd2, 10'h010, 32'h0,        32'h1122EE44, 4'd8},  // R8
      {1'b1, 2'd1, 10'h016, 32'h00005566, 32'h0,        4'd3},  // R3
      {1'b0, 2'd2, 10'h014, 32'h0,        32'h5566CCDD, 4'd8},  // R8
      {1'b0, 2'd2, 10'h010, 32'h0,        32'h1122EE44, 4'd1},  // R1
      {1'b1, 2'd2, 10'h020, 32'hDEADBEEF, 32'h0,        4'd4},  // R4
      {1'b0, 2'd0, 10'h023, 32'h0,        32'h000000DE, 4'd1},  // R1
      {1'b0, 2'd1, 10'h020, 32'h0,        32'h0000BEEF, 4'd3},  // R3
      {1'b1, 2'd2, 10'h030, 32'h30303030, 32'h0,        4'd4},  // R4
      {1'b1, 2'd2, 10'h034, 32'h34343434, 32'h0,        4'd4},  // R4
      {1'b1, 2'd2, 10'h038, 32'h38383838, 32'h0,        4'd4},  // R4
      {1'b1, 2'd2, 10'h03F, 32'hCAFEF00D, 32'h0,        4'd2},  // R2
      {1'b0, 2'd2, 10'h030, 32'h0,        32'h30303030, 4'd4},  // R4
      {1'b0, 2'd2, 10'h034, 32'h0,        32'h34343434, 4'd4},  // R4
      {1'b0, 2'd2, 10'h038, 32'h0,        32'h38383838, 4'd4},  // R4
      {1'b0, 2'd2, 10'h03C, 32'h0,        32'hCAFEF00D, 4'd2},  // R2
      {1'b0, 2'd0, 10'h03E, 32'h0,        32'h000000FE, 4'd1},  // R1
      {1'b0, 2'd2, 10'h020, 32'h0,        32'hDEADBEEF, 4'd2}   // R2
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic drive(input logic w, input logic [1:0] sz, input logic [AW-1:0] a,
                        input logic [31:0] d);
      req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
   endtask

   task automatic wr(input logic [1:0] sz, input logic [AW-1:0] a, input logic [31:0] d);
      drive(1'b1, sz, a, d);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic rd(input string req, input logic [1:0] sz, input logic [AW-1:0] a,
                     input logic [31:0] exp);
      drive(1'b0, sz, a, 32'h0);
      @(negedge clk);
      req_valid = 1'b0;
      check(req, {31'h0, rd_valid}, 32'h1);
      check(req, rd_data, exp);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      check("R6", {31'h0, rd_valid}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic prev_rd;
      int   prev_i;
      repeat (3) @(negedge clk);
      check("R6", {31'h0, rd_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", {31'h0, rd_valid}, 32'h0);

      // table walk, one request per cycle
      prev_rd = 1'b0; prev_i = 0;
      for (int i = 0; i < NV; i++) begin
         if (prev_rd) check($sformatf("R%0d", VEC[prev_i][3:0]), rd_data, VEC[prev_i][35:4]);
         check("R9", {31'h0, rd_valid}, {31'h0, prev_rd});
         drive(VEC[i][80], VEC[i][79:78], VEC[i][77:68], VEC[i][67:36]);
         prev_rd = !VEC[i][80]; prev_i = i;
         @(negedge clk);
      end
      req_valid = 1'b0;
      if (prev_rd) check($sformatf("R%0d", VEC[prev_i][3:0]), rd_data, VEC[prev_i][35:4]);
      @(negedge clk);
      check("R9", {31'h0, rd_valid}, 32'h0);

      // R7 double write fixes a value; R5/R6 posted newer value lost on reset
      wr(2'd2, 10'h040, 32'h01010101);
      wr(2'd2, 10'h040, 32'h01010101);
      wr(2'd2, 10'h040, 32'h02020202);
      rd("R8", 2'd2, 10'h040, 32'h02020202);
      repeat (4) @(negedge clk);
      rd("R5", 2'd0, 10'h041, 32'h00000002);
      do_reset();
      rd("R6", 2'd2, 10'h040, 32'h01010101);
      rd("R7", 2'd2, 10'h040, 32'h01010101);

      // R7 dummy write to another address pushes the earlier write out
      wr(2'd2, 10'h050, 32'h5A5A5A5A);
      wr(2'd0, 10'h060, 32'h00000000);
      do_reset();
      rd("R7", 2'd2, 10'h050, 32'h5A5A5A5A);
      // R10 array contents from before the resets remain
      rd("R10", 2'd2, 10'h014, 32'h5566CCDD);
      rd("R10", 2'd2, 10'h030, 32'h30303030);

      // R5 a partial write not followed by another write is lost
      wr(2'd0, 10'h031, 32'h000000FF);
      rd("R8", 2'd2, 10'h030, 32'h3030FF30);
      do_reset();
      rd("R5", 2'd2, 10'h030, 32'h30303030);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule